// File: doc/BRIEF.md
# I2C Programmable Bus Timing Generator

This block drives the two open-drain wires of an I2C master. A transaction engine asks it for one bus primitive at a time: START, repeated START, a single data bit, or STOP. The block shapes the SCL and SDA waveforms for that primitive and then reports back. Each wire is modelled as a drive-low enable. A high enable pulls the line low, and a low enable releases it.

Every phase of the bus has its own programmable length, counted in ticks of a shared prescaler. The phases are start setup and hold, stop setup, data setup and hold, SCL low and high, and the release before a repeated START. The fields arrive in four packed timing words and one configuration word. A data bit also pays a fixed settle overhead on each SCL edge, and that overhead grows with the input-filter length. A bit period is therefore `(DIV+1)·(LO+HI+2) + 8 + 2·FILT` input clocks.

During the SCL high phase of a bit, the block samples SDA. This sample gives both read data and the ACK/NACK result. If SDA reads low while the master is releasing it, the block flags lost arbitration.

Top module: `i2c_phase_timer`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `done`, `rx_bit` and `arb_lost` are all 0.
- R2: Field positions and codes are as follows. `tim_edge_w` holds start setup in [31:24], start hold in [23:16] and stop setup in [15:8]. `tim_bit_w` holds data setup in [31:24], SCL low LO in [15:8] and SCL high HI in [7:0]. `tim_clk_w` holds the prescaler DIV in [23:16] and the restart release in [7:0]. `tim_hold_w` holds data hold in [7:0]. `cfg_w` holds FILT in [18:16]. One tick T is DIV+1 clocks. The op codes are 0 START, 1 repeated START, 2 bit and 3 STOP. All times below count clock cycles after the edge that accepts the request.
- R3: START begins by releasing both lines. SDA is driven low at (start setup)·T while SCL stays released. SCL is driven low, and `done` rises, at (start setup + start hold)·T.
- R4: Repeated START releases both lines at cycle 0 and holds them released for (release)·T. It then runs the START sequence, so SDA falls at (release + start setup)·T and SCL falls with `done` at (release + start setup + start hold)·T.
- R5: A bit begins with SCL low and a settle of S = 4+FILT clocks. SDA takes its new value at S + HD·T, or at cycle 0 when HD is 0. SCL is released at S + max(LO+1, HD+SU)·T, where HD is the data hold and SU is the data setup.
- R6: After SCL is released, a bit waits a further S + (HI+1)·T clocks, then drives SCL low and raises `done`. When HD+SU ≤ LO+1, the total equals (DIV+1)·(LO+HI+2) + 8 + 2·FILT.
- R7: `rx_bit` takes SDA at the clock edge lying S + ((HI+2)/2)·T after SCL is released, where the division rounds down. It holds that value until the next sample.
- R8: `arb_lost` is set when a bit with value 1 samples SDA low. A bit with value 0 never sets it. Every accepted request clears it.
- R9: STOP has no settle. It drives SDA low at HD·T and releases SCL at max(LO+1, HD+SU)·T. It then releases SDA, and raises `done`, a further (stop setup)·T later.
- R10: A count field of 0 lasts one tick.
- R11: A request is accepted only while the block is idle, `req` is 1 and `done` is 0. `op` and `bit_in` are captured at acceptance, and later changes have no effect until the next request. `done` is a one-cycle pulse.
- R12: SDA changes while SCL is released only at the START falling edge and the STOP rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tim_edge_w | input | 32 | Start setup, start hold, stop setup |
| tim_bit_w | input | 32 | Data setup, SCL low, SCL high |
| tim_clk_w | input | 32 | Prescaler and restart release |
| tim_hold_w | input | 32 | Data hold |
| cfg_w | input | 32 | Configuration; input filter length in [18:16] |
| req | input | 1 | Primitive request, held until `done` |
| op | input | 2 | Primitive code |
| bit_in | input | 1 | Bit value to send (1 releases SDA) |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Drive SCL low |
| sda_oe | output | 1 | Drive SDA low |
| done | output | 1 | Primitive finished, one cycle |
| rx_bit | output | 1 | SDA level sampled in the last bit |
| arb_lost | output | 1 | Sent 1 but read 0 |

## Verification
Data bits are run under a table of eight timing sets. The sets vary the prescaler, LO and HI, the hold and setup counts, the filter length and the bit value. Separate timings of the SDA change, the SCL release and `done` show whether the hold, the stretched low phase, the high phase and the settle overhead are each counted correctly. One set breaks HD+SU ≤ LO+1, which isolates the low-phase stretch, and one set uses all-zero counts. Directed sequences cover START, repeated START after a driven-low bit, and STOP after a released bit. A pull on SDA that starts exactly one cycle before or at the sampling edge pins down the sampling point. Changing `op` and `bit_in` in the middle of an operation shows that both are captured at acceptance.

// File: rtl/i2c_phase_timer.sv
`timescale 1ns/1ps
module i2c_phase_timer #(
  parameter int EDGE_OVH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tim_edge_w,
  input  logic [31:0] tim_bit_w,
  input  logic [31:0] tim_clk_w,
  input  logic [31:0] tim_hold_w,
  input  logic [31:0] cfg_w,
  input  logic        req,
  input  logic [1:0]  op,
  input  logic        bit_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        done,
  output logic        rx_bit,
  output logic        arb_lost
);
  localparam int CW = 9;
  localparam int SW = $clog2(EDGE_OVH + 8) + 1;

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_REL  = 3'd1;
  localparam logic [2:0] ST_SSU  = 3'd2;
  localparam logic [2:0] ST_SHD  = 3'd3;
  localparam logic [2:0] ST_BLO  = 3'd4;
  localparam logic [2:0] ST_BHI  = 3'd5;
  localparam logic [2:0] ST_PLO  = 3'd6;
  localparam logic [2:0] ST_PSU  = 3'd7;

  localparam logic [1:0] OP_START  = 2'd0;
  localparam logic [1:0] OP_RSTART = 2'd1;
  localparam logic [1:0] OP_BIT    = 2'd2;
  localparam logic [1:0] OP_STOP   = 2'd3;

  wire [7:0] t_ssu = tim_edge_w[31:24];
  wire [7:0] t_shd = tim_edge_w[23:16];
  wire [7:0] t_psu = tim_edge_w[15:8];
  wire [7:0] t_dsu = tim_bit_w[31:24];
  wire [7:0] t_lo  = tim_bit_w[15:8];
  wire [7:0] t_hi  = tim_bit_w[7:0];
  wire [7:0] t_div = tim_clk_w[23:16];
  wire [7:0] t_rel = tim_clk_w[7:0];
  wire [7:0] t_dhd = tim_hold_w[7:0];
  wire [2:0] filt  = cfg_w[18:16];

  logic unused_fields;
  assign unused_fields = ^{tim_edge_w[7:0], tim_bit_w[23:16], tim_clk_w[31:24],
                           tim_clk_w[15:8], tim_hold_w[31:8], cfg_w[31:19], cfg_w[15:0]};

  logic [2:0]    st, st_n;
  logic [7:0]    pre;
  logic [CW-1:0] tcnt;
  logic [SW-1:0] settle;
  logic bit_q, scl_q, sda_q, done_q, rx_q, arb_q;

  function automatic logic reach(input logic [CW-1:0] n, input logic [7:0] c);
    return n >= CW'(c);
  endfunction

  wire           tick     = (settle == '0) && (pre == t_div);
  wire [CW-1:0]  nxt      = tcnt + CW'(1);
  wire [CW-1:0]  lo_a     = CW'(t_lo) + CW'(1);
  wire [CW-1:0]  lo_b     = CW'(t_dhd) + CW'(t_dsu);
  wire [CW-1:0]  low_len  = (lo_a >= lo_b) ? lo_a : lo_b;
  wire [CW-1:0]  hi_len   = CW'(t_hi) + CW'(1);
  wire [CW-1:0]  hi_mid   = (hi_len + CW'(1)) >> 1;
  wire [SW-1:0]  settle_n = SW'(EDGE_OVH) + SW'(filt);
  wire           hd_hit   = tick && (nxt == CW'(t_dhd));
  wire           accept   = (st == ST_IDLE) && req && !done_q;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (accept) begin
        case (op)
          OP_START:  st_n = ST_SSU;
          OP_RSTART: st_n = ST_REL;
          OP_BIT:    st_n = ST_BLO;
          default:   st_n = ST_PLO;
        endcase
      end
      ST_REL:  if (tick && reach(nxt, t_rel)) st_n = ST_SSU;
      ST_SSU:  if (tick && reach(nxt, t_ssu)) st_n = ST_SHD;
      ST_SHD:  if (tick && reach(nxt, t_shd)) st_n = ST_IDLE;
      ST_BLO:  if (tick && nxt >= low_len)    st_n = ST_BHI;
      ST_BHI:  if (tick && nxt >= hi_len)     st_n = ST_IDLE;
      ST_PLO:  if (tick && nxt >= low_len)    st_n = ST_PSU;
      default: if (tick && reach(nxt, t_psu)) st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pre    <= '0;
      tcnt   <= '0;
      settle <= '0;
    end else begin
      st <= st_n;
      if (st_n != st) begin
        pre    <= '0;
        tcnt   <= '0;
        settle <= (st_n == ST_BLO || st_n == ST_BHI) ? settle_n : '0;
      end else if (st != ST_IDLE) begin
        if (settle != '0) settle <= settle - SW'(1);
        else if (pre == t_div) begin
          pre  <= '0;
          tcnt <= nxt;
        end else pre <= pre + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          arb_q <= 1'b0;
          bit_q <= (op == OP_BIT) ? bit_in : 1'b0;
          case (op)
            OP_START, OP_RSTART: begin
              scl_q <= 1'b0;
              sda_q <= 1'b0;
            end
            OP_BIT:  if (t_dhd == 8'd0) sda_q <= ~bit_in;
            default: if (t_dhd == 8'd0) sda_q <= 1'b1;
          endcase
        end
        ST_SSU: if (st_n == ST_SHD) sda_q <= 1'b1;
        ST_SHD: if (st_n == ST_IDLE) begin
          scl_q  <= 1'b1;
          done_q <= 1'b1;
        end
        ST_BLO, ST_PLO: begin
          if (hd_hit) sda_q <= ~bit_q;
          if (st_n != st) scl_q <= 1'b0;
        end
        ST_BHI: begin
          if (tick && nxt == hi_mid) begin
            rx_q <= sda_in;
            if (bit_q && !sda_in) arb_q <= 1'b1;
          end
          if (st_n == ST_IDLE) begin
            scl_q  <= 1'b1;
            done_q <= 1'b1;
          end
        end
        ST_PSU: if (st_n == ST_IDLE) begin
          sda_q  <= 1'b0;
          done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign done     = done_q;
  assign rx_bit   = rx_q;
  assign arb_lost = arb_q;
endmodule

// File: rtl/i2c_phase_timer_chk.sv
`timescale 1ns/1ps
module i2c_phase_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done,
  input logic       arb_lost,
  input logic [2:0] st
);
  assert_sda_edge_scl_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ((sda_oe && st == 3'd3) || (!sda_oe && done)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && $past(st) == 3'd0) |-> ($stable(scl_oe) && $stable(sda_oe)));

  // R3 and R9: a finished primitive leaves SCL low, or both lines free after STOP
  assert_done_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_oe || !sda_oe));

  assert_arb_in_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !scl_oe);

  assert_arb_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && $past(st) == 3'd0) |-> !arb_lost);
endmodule

bind i2c_phase_timer i2c_phase_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done(done), .arb_lost(arb_lost), .st(st)
);

// File: tb/test_i2c_phase_timer.sv
`timescale 1ns/1ps
module test_i2c_phase_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tim_edge_w = '0, tim_bit_w = '0, tim_clk_w = '0, tim_hold_w = '0, cfg_w = '0;
  logic req = 1'b0, bit_in = 1'b0, pull = 1'b0;
  logic [1:0] op = 2'd0;
  logic sda_in, scl_oe, sda_oe, done, rx_bit, arb_lost;

  assign sda_in = !(sda_oe || pull);

  always #2.5 clk = ~clk;

  i2c_phase_timer i_i2c_phase_timer (
    .clk(clk), .rst_n(rst_n), .tim_edge_w(tim_edge_w), .tim_bit_w(tim_bit_w),
    .tim_clk_w(tim_clk_w), .tim_hold_w(tim_hold_w), .cfg_w(cfg_w), .req(req),
    .op(op), .bit_in(bit_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .rx_bit(rx_bit), .arb_lost(arb_lost)
  );

  // [47:40] div [39:32] lo [31:24] hi [23:16] hold [15:8] setup [7:4] bit [3:0] filt
  localparam logic [47:0] VECS [8] = '{
    48'h000605020210, 48'h010403010112, 48'h020304000117, 48'h000202030311,
    48'h030000000010, 48'h000506020103, 48'h040807030215, 48'h000a09040400
  };

  int checks = 0, errors = 0;
  int e_sda1, e_sda2, e_scl1, e_scl2, e_done, done_after;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int dv, input int lo, input int hi, input int hd, input int su,
                         input int f, input int ss, input int sh, input int sp, input int rel);
    tim_edge_w = {8'(ss), 8'(sh), 8'(sp), 8'd0};
    tim_bit_w  = {8'(su), 8'd0, 8'(lo), 8'(hi)};
    tim_clk_w  = {8'd0, 8'(dv), 8'd0, 8'(rel)};
    tim_hold_w = {24'd0, 8'(hd)};
    cfg_w      = {13'd0, 3'(f), 16'd0};
  endtask

  task automatic run_op(input logic [1:0] o, input logic b, input int pf, input int pt,
                        input logic scr);
    logic ps, pc;
    @(negedge clk);
    op = o; bit_in = b; req = 1'b1; pull = 1'b0;
    ps = sda_oe; pc = scl_oe;
    e_sda1 = -1; e_sda2 = -1; e_scl1 = -1; e_scl2 = -1; e_done = -1;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (sda_oe !== ps) begin
        if (e_sda1 < 0) e_sda1 = n;
        e_sda2 = n; ps = sda_oe;
      end
      if (scl_oe !== pc) begin
        if (e_scl1 < 0) e_scl1 = n;
        e_scl2 = n; pc = scl_oe;
      end
      pull = (n >= pf) && (n < pt);
      if (scr && n == 3) begin
        op = ~o; bit_in = ~b;
      end
      if (done) begin
        e_done = n; req = 1'b0;
        break;
      end
    end
    pull = 1'b0;
    @(negedge clk);
    done_after = int'(done);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 rx_bit", int'(rx_bit), 0);
    chk("R1 arb_lost", int'(arb_lost), 0);

    // T=2, S=5, lowt=6, high=5 ticks, mid=3
    set_cfg(1, 5, 4, 2, 2, 1, 3, 2, 4, 2);
    run_op(2'd0, 1'b0, 9999, 0, 1'b0);
    chk("R3 sda fall", e_sda1, 6);
    chk("R3 scl fall", e_scl1, 10);
    chk("R2 start done", e_done, 10);
    chk("R12 sda before scl", int'(e_sda1 < e_scl1), 1);
    chk("R11 done one cycle", done_after, 0);
    chk("R3 lines", int'({sda_oe, scl_oe}), 3);

    run_op(2'd2, 1'b0, 9999, 0, 1'b0);
    chk("R5 bit0 sda held", e_sda1, -1);
    chk("R6 bit0 done", e_done, 32);

    run_op(2'd1, 1'b0, 9999, 0, 1'b0);
    chk("R4 sda release", e_sda1, 0);
    chk("R4 sda fall", e_sda2, 10);
    chk("R4 scl release", e_scl1, 0);
    chk("R4 scl fall", e_scl2, 14);
    chk("R4 done", e_done, 14);

    run_op(2'd2, 1'b1, 9999, 0, 1'b0);
    chk("R5 bit1 sda", e_sda1, 9);
    run_op(2'd3, 1'b0, 9999, 0, 1'b0);
    chk("R9 sda low", e_sda1, 4);
    chk("R9 scl release", e_scl1, 12);
    chk("R9 sda release", e_sda2, 20);
    chk("R9 done", e_done, 20);
    chk("R12 stop edge after scl", int'(e_sda2 > e_scl1), 1);
    chk("R9 lines", int'({sda_oe, scl_oe}), 0);

    // sampling edge is cycle 28 of the bit
    run_op(2'd0, 1'b0, 9999, 0, 1'b0);
    run_op(2'd2, 1'b1, 27, 1000, 1'b0);
    chk("R7 early pull rx", int'(rx_bit), 0);
    chk("R8 arb set", int'(arb_lost), 1);
    run_op(2'd2, 1'b1, 28, 1000, 1'b0);
    chk("R7 late pull rx", int'(rx_bit), 1);
    chk("R8 arb cleared", int'(arb_lost), 0);
    run_op(2'd2, 1'b0, 0, 1000, 1'b0);
    chk("R8 bit0 no arb", int'(arb_lost), 0);
    run_op(2'd3, 1'b0, 9999, 0, 1'b0);

    run_op(2'd0, 1'b0, 9999, 0, 1'b0);
    run_op(2'd2, 1'b1, 9999, 0, 1'b1);
    chk("R11 captured sda", e_sda1, 9);
    chk("R11 captured scl", e_scl1, 17);
    chk("R11 captured done", e_done, 32);
    chk("R11 captured rx", int'(rx_bit), 1);
    chk("R11 done pulse", done_after, 0);
    run_op(2'd3, 1'b0, 9999, 0, 1'b0);

    for (int i = 0; i < 8; i++) begin
      logic [47:0] v;
      int dv, lo, hi, hd, su, bv, f, s, t, lowt;
      string tg;
      v = VECS[i];
      dv = int'(v[47:40]); lo = int'(v[39:32]); hi = int'(v[31:24]);
      hd = int'(v[23:16]); su = int'(v[15:8]); bv = int'(v[7:4]); f = int'(v[3:0]);
      s = 4 + f; t = dv + 1;
      lowt = (lo + 1 >= hd + su) ? lo + 1 : hd + su;
      tg = (i == 4) ? "R10" : "R5";
      set_cfg(dv, lo, hi, hd, su, f, 1, 1, 1, 1);
      run_op(2'd0, 1'b0, 9999, 0, 1'b0);
      run_op(2'd2, bv[0], 9999, 0, 1'b0);
      if (bv != 0) chk({tg, " sda change"}, e_sda1, (hd == 0) ? 0 : s + hd * t);
      else chk("R5 sda held", e_sda1, -1);
      chk({tg, " scl release"}, e_scl1, s + lowt * t);
      chk("R6 bit done", e_done, 2 * s + (lowt + hi + 1) * t);
      if (hd + su <= lo + 1) chk("R6 period", e_done, t * (lo + hi + 2) + 8 + 2 * f);
      chk("R7 rx", int'(rx_bit), bv);
      chk("R8 no arb", int'(arb_lost), 0);
      run_op(2'd3, 1'b0, 9999, 0, 1'b0);
    end

    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_op(2'd0, 1'b0, 9999, 0, 1'b0);
    chk("R10 start sda", e_sda1, 1);
    chk("R10 start done", e_done, 2);
    run_op(2'd3, 1'b0, 9999, 0, 1'b0);
    chk("R10 stop scl", e_scl1, 1);
    chk("R10 stop done", e_done, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule